// File: doc/BRIEF.md
# Double-Precision Exponent Extraction Unit

This unit takes one 64-bit IEEE-754 binary64 operand and returns another binary64 value equal to floor(log2(|x|)). That value is the unbiased exponent of the operand, written as a floating-point number. The operand's sign never matters. Subnormal operands are normalised to their true negative exponent. A zero operand gives negative infinity, an infinite operand gives positive infinity, and a NaN comes back in quiet form.

An operand is presented together with `valid_in` and a flush-subnormals control bit `daz`. The result and two flags (`flag_invalid` and `flag_denormal`) come out of one register stage on the next clock and are qualified by `valid_out`. The leading-one search and the integer-to-double conversion are pure combinational logic, so the unit accepts a new operand every cycle.

Top module: `dp_expo_extract`

## Requirements
- R1: `valid_out` is high in the cycle after every cycle in which `valid_in` is high, and low after every cycle in which it is low. `result`, `flag_invalid` and `flag_denormal` belong to the operand accepted one cycle earlier.
- R2: Bit 63 of the operand has no effect on the result or the flags unless the operand is a NaN.
- R3: A NaN operand (exponent field bits 62:52 all ones, fraction bits 51:0 nonzero) returns the operand with bit 51 forced to one and every other bit unchanged. `flag_invalid` is high exactly when bit 51 of the operand was zero, which marks a signalling NaN.
- R4: An infinite operand (exponent all ones, fraction zero), of either sign, returns 0x7FF0000000000000 with both flags low.
- R5: An operand with a zero exponent field and a zero fraction returns 0xFFF0000000000000 with both flags low.
- R6: When `daz` is high, every operand with a zero exponent field returns 0xFFF0000000000000 and `flag_denormal` stays low.
- R7: An operand with an exponent field E between 1 and 2046 returns E-1023 converted exactly to binary64. E=1023 gives +0.0 (all bits zero).
- R8: With `daz` low, an operand with a zero exponent field and a nonzero fraction returns k-1074 converted exactly to binary64, where k is the bit index (0 to 51) of the most significant one in the fraction. `flag_denormal` is high for this operand.
- R9: Both flags are low whenever `valid_out` is low and for every operand not named in R3 or R8. The two flags are never high together.
- R10: While reset is held, `valid_out`, `result` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operand and `daz` are valid this cycle |
| operand | input | 64 | Binary64 operand |
| daz | input | 1 | Treat subnormal operands as zero |
| valid_out | output | 1 | Result and flags are valid |
| result | output | 64 | floor(log2(\|operand\|)) as binary64 |
| flag_invalid | output | 1 | Operand was a signalling NaN |
| flag_denormal | output | 1 | Operand was a subnormal that was not flushed |

## Verification
The hardest cases to reach are the subnormal ones. Each of the 52 possible leading-one positions must be tested with both settings of `daz`, and different patterns must fill the bits below the leading one so that a priority encoder which drops its priority order is caught. The stimulus walks a single leading one through every fraction bit and sets the lower bits to zeros, ones and an alternating pattern. It also sweeps every exponent field value with both signs and both `daz` settings. The expected value is the integer exponent formed as a real number and turned into bits by the simulator.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam int DPX_EXP_W  = 11;
  localparam int DPX_FRAC_W = 52;
  localparam int DPX_BIAS   = 1023;
  localparam int DPX_INT_W  = 12;

  typedef enum logic [2:0] {
    CLS_NORM = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_ZERO = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } dpx_cls_e;

  // Unbiased exponent of a normal operand.
  function automatic logic signed [DPX_INT_W-1:0] norm_unbiased(
    input logic [DPX_EXP_W-1:0] e
  );
    return DPX_INT_W'(int'(e) - DPX_BIAS);
  endfunction

  // Unbiased exponent of a subnormal operand whose fraction MSB is at idx.
  function automatic logic signed [DPX_INT_W-1:0] sub_unbiased(
    input logic [5:0] idx
  );
    return DPX_INT_W'(int'(idx) - (DPX_BIAS + DPX_FRAC_W - 1));
  endfunction

  // Quiet form of a NaN: top fraction bit set, everything else kept.
  function automatic logic [63:0] quiet_nan(input logic [63:0] op);
    return op | (64'd1 << (DPX_FRAC_W - 1));
  endfunction

endpackage

// File: rtl/dpx_lod.sv
module dpx_lod #(
  parameter int W     = 52,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  // Priority encoder: the highest set bit wins because it is visited last.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int b = 0; b < W; b++) begin
      if (vec[b]) begin
        idx   = IDX_W'(b);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpx_classify.sv
module dpx_classify
  import dpx_pkg::*;
#(
  parameter int EXP_W  = DPX_EXP_W,
  parameter int FRAC_W = DPX_FRAC_W
) (
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W-1:0] frac_f,
  input  logic              daz,
  output dpx_cls_e          cls
);
  logic exp_max, exp_min, frac_nz;

  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    if (exp_max && frac_nz)
      cls = frac_f[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
    else if (exp_max)
      cls = CLS_INF;
    else if (exp_min && (!frac_nz || daz))
      cls = CLS_ZERO;
    else if (exp_min)
      cls = CLS_SUB;
    else
      cls = CLS_NORM;
  end
endmodule

// File: rtl/dpx_int2dbl.sv
module dpx_int2dbl
  import dpx_pkg::*;
#(
  parameter int INT_W  = DPX_INT_W,
  parameter int EXP_W  = DPX_EXP_W,
  parameter int FRAC_W = DPX_FRAC_W,
  parameter int BIAS   = DPX_BIAS
) (
  input  logic signed [INT_W-1:0]   n,
  output logic [EXP_W+FRAC_W:0]     dbl
);
  localparam int MAG_W = INT_W - 1;
  localparam int P_W   = $clog2(MAG_W);
  localparam int SH_W  = $clog2(FRAC_W + 1);

  logic signed [INT_W-1:0] n_neg;
  logic [MAG_W-1:0]        mag;
  logic [P_W-1:0]          msb_pos;
  logic                    nz;
  logic [FRAC_W:0]         mag_ext, mag_sh;
  logic [SH_W-1:0]         shamt;

  assign n_neg = -n;
  assign mag   = n[INT_W-1] ? n_neg[MAG_W-1:0] : n[MAG_W-1:0];

  dpx_lod #(.W(MAG_W), .IDX_W(P_W)) u_mag_lod (
    .vec  (mag),
    .idx  (msb_pos),
    .found(nz)
  );

  // Align the leading one onto the hidden-bit position; it is then dropped.
  assign mag_ext = {{(FRAC_W + 1 - MAG_W){1'b0}}, mag};
  assign shamt   = SH_W'(FRAC_W) - SH_W'(msb_pos);
  assign mag_sh  = mag_ext << shamt;

  always_comb begin
    if (!nz)
      dbl = '0;
    else
      dbl = {n[INT_W-1], EXP_W'(msb_pos) + EXP_W'(BIAS), mag_sh[FRAC_W-1:0]};
  end
endmodule

// File: rtl/dp_expo_extract.sv
module dp_expo_extract
  import dpx_pkg::*;
#(
  parameter int EXP_W  = DPX_EXP_W,
  parameter int FRAC_W = DPX_FRAC_W,
  parameter int INT_W  = DPX_INT_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_in,
  input  logic [63:0] operand,
  input  logic        daz,
  output logic        valid_out,
  output logic [63:0] result,
  output logic        flag_invalid,
  output logic        flag_denormal
);
  localparam int LIDX_W = $clog2(FRAC_W);
  localparam logic [63:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [63:0] NEG_INF = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [EXP_W-1:0]        exp_f;
  logic [FRAC_W-1:0]       frac_f;
  dpx_cls_e                cls;
  logic [LIDX_W-1:0]       lead_idx;
  logic                    lead_found;
  logic signed [INT_W-1:0] unb;
  logic [63:0]             conv;
  logic [63:0]             res_nxt;

  // Named internal events, used by the assertions below.
  logic ev_snan, ev_nan, ev_inf, ev_zero, ev_sub;

  assign exp_f  = operand[62:52];
  assign frac_f = operand[51:0];

  dpx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .exp_f (exp_f),
    .frac_f(frac_f),
    .daz   (daz),
    .cls   (cls)
  );

  dpx_lod #(.W(FRAC_W), .IDX_W(LIDX_W)) u_frac_lod (
    .vec  (frac_f),
    .idx  (lead_idx),
    .found(lead_found)
  );

  assign ev_snan = (cls == CLS_SNAN);
  assign ev_nan  = (cls == CLS_SNAN) || (cls == CLS_QNAN);
  assign ev_inf  = (cls == CLS_INF);
  assign ev_zero = (cls == CLS_ZERO);
  assign ev_sub  = (cls == CLS_SUB);

  assign unb = ev_sub ? sub_unbiased(6'(lead_idx)) : norm_unbiased(exp_f);

  dpx_int2dbl #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cvt (
    .n  (unb),
    .dbl(conv)
  );

  always_comb begin
    if (ev_nan)       res_nxt = quiet_nan(operand);
    else if (ev_inf)  res_nxt = POS_INF;
    else if (ev_zero) res_nxt = NEG_INF;
    else              res_nxt = conv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_denormal <= 1'b0;
    end else begin
      valid_out     <= valid_in;
      flag_invalid  <= valid_in && ev_snan;
      flag_denormal <= valid_in && ev_sub;
      if (valid_in) result <= res_nxt;
    end
  end

  // R1
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  // R3
  snan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ev_snan) |=> (flag_invalid && result[51] && (result[62:52] == '1)));
  // R4
  inf_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ev_inf) |=> (result == POS_INF && !flag_invalid && !flag_denormal));
  // R5
  zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ev_zero) |=> (result == NEG_INF && !flag_denormal));
  // R8
  sub_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sub |-> lead_found);
  // R8
  den_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_denormal |-> ($past(operand[62:52]) == '0 && !$past(daz)));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_invalid && flag_denormal));
  // R9
  flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> (!flag_invalid && !flag_denormal));
endmodule

// File: tb/dp_expo_extract_tb.sv
`timescale 1ns/1ps
module dp_expo_extract_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [63:0] operand = '0;
  logic        daz = 1'b0;
  logic        valid_out;
  logic [63:0] result;
  logic        flag_invalid, flag_denormal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dp_expo_extract u_dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .operand(operand),
    .daz(daz), .valid_out(valid_out), .result(result),
    .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
  );

  // Reference computed from the requirements through the simulator's reals.
  function automatic void model(input logic [63:0] op, input logic dz,
                                output logic [63:0] r, output logic inv,
                                output logic den);
    int e = int'(op[62:52]);
    logic [51:0] f = op[51:0];
    int msb = -1;
    inv = 1'b0; den = 1'b0;
    if (e == 2047) begin
      if (f != 0) begin r = op | 64'h0008_0000_0000_0000; inv = ~op[51]; end
      else r = 64'h7FF0_0000_0000_0000;
    end else if (e == 0) begin
      if (f == 0 || dz) r = 64'hFFF0_0000_0000_0000;
      else begin
        for (int k = 0; k < 52; k++) if (f[k]) msb = k;
        r = $realtobits(real'(msb - 1074));
        den = 1'b1;
      end
    end else r = $realtobits(real'(e - 1023));
  endfunction

  function automatic string tag_of(input logic [63:0] op, input logic dz);
    if (op[62:52] == 11'h7FF && op[51:0] != 0) return "R3";
    if (op[63]) return "R2";
    if (op[62:52] == 11'h7FF) return "R4";
    if (op[62:52] == 0) begin
      if (op[51:0] == 0) return "R5";
      if (dz) return "R6";
      return "R8";
    end
    return "R7";
  endfunction

  // Called at a falling edge; checks at the next falling edge.
  task automatic step(input logic [63:0] op, input logic dz);
    logic [63:0] er; logic ei, ed;
    string t = tag_of(op, dz);
    operand = op; daz = dz; valid_in = 1'b1;
    @(negedge clk);
    model(op, dz, er, ei, ed);
    checks++;
    if (valid_out !== 1'b1 || result !== er || flag_invalid !== ei || flag_denormal !== ed) begin
      errors++;
      $display("FAIL %s op=%h daz=%0b got v=%0b r=%h i=%0b d=%0b exp v=1 r=%h i=%0b d=%0b",
               t, op, dz, valid_out, result, flag_invalid, flag_denormal, er, ei, ed);
    end
    // R9: the flags are never high together
    if (flag_invalid && flag_denormal) begin
      checks++; errors++;
      $display("FAIL R9 both flags high got i=1 d=1 exp at most one");
    end
  endtask

  task automatic bubble();
    logic [63:0] held = result;
    valid_in = 1'b0; operand = 64'h0000_0000_0000_0001; daz = 1'b0;
    @(negedge clk);
    checks++;
    // R1, R9: no valid, no flags, result held
    if (valid_out !== 1'b0 || flag_invalid || flag_denormal || result !== held) begin
      errors++;
      $display("FAIL R1 bubble got v=%0b i=%0b d=%0b r=%h exp v=0 i=0 d=0 r=%h",
               valid_out, flag_invalid, flag_denormal, result, held);
    end
  endtask

  initial begin
    logic [51:0] fr [4];
    fr[0] = 52'h0; fr[1] = 52'h1; fr[2] = 52'hF_FFFF_FFFF_FFFF; fr[3] = 52'h5_A5A5_A5A5_A5A5;
    operand = 64'hFFFF_FFFF_FFFF_FFFF; valid_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    // R10: reset state
    if (valid_out !== 1'b0 || result !== 64'h0 || flag_invalid || flag_denormal) begin
      errors++;
      $display("FAIL R10 reset got v=%0b r=%h i=%0b d=%0b exp all zero",
               valid_out, result, flag_invalid, flag_denormal);
    end
    rst_n = 1'b1;
    valid_in = 1'b0;
    @(negedge clk);
    // R7, R4, R5, R2, R3: every exponent field, both signs, both daz values
    for (int e = 0; e < 2048; e++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
          for (int q = 0; q < 4; q++)
            step({s[0], e[10:0], fr[q]}, d[0]);
    bubble();
    // R8, R6: each leading-one position with varied lower bits
    for (int k = 0; k < 52; k++)
      for (int p = 0; p < 3; p++)
        for (int d = 0; d < 2; d++) begin
          logic [51:0] low = (52'd1 << k) - 52'd1;
          logic [51:0] f = (52'd1 << k) | (p == 0 ? 52'd0 : p == 1 ? low : (low & 52'hA_AAAA_AAAA_AAAA));
          step({1'b0, 11'd0, f}, d[0]);
          step({1'b1, 11'd0, f}, d[0]);
        end
    // R3: signalling and quiet NaN payloads, both signs
    for (int k = 0; k < 51; k++) begin
      step({1'b0, 11'h7FF, 1'b0, 51'd1 << k}, 1'b0);
      step({1'b1, 11'h7FF, 1'b0, 51'd1 << k}, 1'b1);
      step({1'b0, 11'h7FF, 1'b1, 51'd1 << k}, 1'b0);
    end
    step(64'h7FF8_0000_0000_0000, 1'b0);
    // R7: exact values around the bias
    step(64'h3FF0_0000_0000_0000, 1'b0);
    bubble();
    step(64'h4000_0000_0000_0000, 1'b0);
    bubble();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog got no completion exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule